// File: doc/BRIEF.md
# Register-Mapped Compute Engine Front End

This block sits between a processor's AXI4-Lite port and a compute engine that has a start input and a done output. Software writes the engine's input words into a bank of ordinary read/write registers, then writes to a kick register. The kick register pulses the engine's start input and withdraws the "results ready" status. When the engine raises its done strobe, the block captures every result word and sets the ready status in the same clock edge.

Reading the first result word is the synchronisation point. If the results are not ready, the read response is held back until they are. Software can therefore run a loop of writing operands, writing the kick, and reading results with no status polling. The other result words are plain read-only registers that answer at once. Registers are 32 bits wide and word aligned. The operands start at offset 0x00. The kick register follows the last operand, at 0x18 with six operands. The results start at 0x20.

Top module: `accw_top`

## Requirements
- R1: After reset, every operand word and every captured result is zero, results-ready is clear, AWREADY, WREADY and ARREADY are 1, BVALID, RVALID and the engine start output are 0.
- R2: Operand registers at offsets 0x00 to 0x14 read back what was written. WSTRB bit i gates byte i, which is data bits 8i+7 to 8i. The operand words appear on the engine operand bus with operand k at bits 32k+31 to 32k.
- R3: The write address and write data may arrive together or either one first. BVALID rises only after both have been accepted, with BRESP equal to 0 (OKAY), and stays high until BREADY. No further address or data is accepted while one is held or while BVALID is high.
- R4: A write of any data to the kick register at offset 0x18 gives a start pulse exactly one cycle long and clears results-ready. A read of 0x18 returns results-ready in bit 0 and zero in all other bits.
- R5: A done strobe captures all result words and sets results-ready on the same edge. The captured words stay unchanged until the next done strobe.
- R6: A read of offset 0x20 while results-ready is clear produces no RVALID, and ARREADY stays low, until a done strobe arrives. The read then returns the captured first result.
- R7: Result registers at 0x24 and above, and offset 0x20 when results-ready is set, give RVALID on the cycle after the address is accepted. They return the captured value whatever the ready status.
- R8: Writes to result offsets or to unmapped offsets complete with OKAY and change nothing. Reads of unmapped offsets return 0.
- R9: If a kick write arrives while a read of 0x20 is held back, the read stays held until the engine's next done strobe. It then returns the newly captured first result.
- R10: Once RVALID is high, it stays high and RDATA stays unchanged until RREADY. RRESP is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_operands | output | NUM_OPS*32 | All operand words, operand 0 in the low bits |
| eng_done | input | 1 | Engine completion strobe |
| eng_results | input | NUM_RES*32 | Engine result words, result 0 in the low bits |

## Verification
The assertions check, on every cycle, the channel rules. A write response rises only after both halves of the write are held, and it is held until accepted. Read data stays stable under backpressure, and no read address is taken while a read is held back. A kick always leaves the ready status clear, and a done strobe without a kick always sets it. A held-back read never completes while the results are not ready. Only the bench's scenarios can show the data path. This covers the byte-strobe merging, the arrival orders of address and data, writes that are ignored, the value returned when a held-back read is released, and the rule that a kick during a held-back read pushes the release to the next computation.

// File: rtl/accw_pkg.sv
package accw_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;

  typedef enum logic [1:0] {
    REG_OPERAND,
    REG_KICK,
    REG_RESULT,
    REG_NONE
  } reg_kind_e;

  // Byte-wise merge of a write into a stored word.
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    for (int b = 0; b < STRB_W; b++) begin
      res[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return res;
  endfunction

  // Map a word index onto the register kinds.
  function automatic reg_kind_e classify(input int unsigned idx, input int unsigned n_ops,
                                         input int unsigned res_idx, input int unsigned n_res);
    if (idx < n_ops) return REG_OPERAND;
    if (idx == n_ops) return REG_KICK;
    if (idx >= res_idx && idx < res_idx + n_res) return REG_RESULT;
    return REG_NONE;
  endfunction
endpackage

// File: rtl/accw_wr_chan.sv
module accw_wr_chan
  import accw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_held, w_held;
  logic aw_hs, w_hs;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held && !bvalid;
  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid && wready;
  assign wr_fire = aw_held && w_held;
  assign bresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      bvalid  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (aw_hs) begin
        aw_held <= 1'b1;
        wr_addr <= awaddr;
      end
      if (w_hs) begin
        w_held  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_fire) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  // R3: a response only follows a cycle where both halves were held
  p_resp_after_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(aw_held && w_held));
  // R3: response held until accepted
  p_resp_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R3: nothing new accepted while the response is outstanding
  p_no_accept_in_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready);
endmodule

// File: rtl/accw_regs.sv
module accw_regs
  import accw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_OPS  = 6,
  parameter int unsigned NUM_RES  = 4,
  parameter int unsigned RES_BASE = 32'h20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_fire,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [STRB_W-1:0]         wr_strb,
  input  logic                      eng_done,
  input  logic [NUM_RES*DATA_W-1:0] eng_results,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [NUM_OPS*DATA_W-1:0] eng_operands,
  output logic                      kick,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         rd_word,
  output logic [DATA_W-1:0]         res0_word
);
  localparam int unsigned RES_IDX = RES_BASE / 4;

  logic [DATA_W-1:0] op_q  [NUM_OPS];
  logic [DATA_W-1:0] res_q [NUM_RES];
  logic [NUM_RES*DATA_W-1:0] res_flat;

  int unsigned wr_idx, rd_idx;
  reg_kind_e   wr_kind, rd_kind;

  assign wr_idx  = 32'(wr_addr[ADDR_W-1:2]);
  assign rd_idx  = 32'(rd_addr[ADDR_W-1:2]);
  assign wr_kind = classify(wr_idx, NUM_OPS, RES_IDX, NUM_RES);
  assign rd_kind = classify(rd_idx, NUM_OPS, RES_IDX, NUM_RES);
  assign kick    = wr_fire && (wr_kind == REG_KICK);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    always_ff @(posedge clk) begin
      if (!rst_n) op_q[i] <= '0;
      else if (wr_fire && wr_kind == REG_OPERAND && wr_idx == i)
        op_q[i] <= merge_bytes(op_q[i], wr_data, wr_strb);
    end
    assign eng_operands[i*DATA_W +: DATA_W] = op_q[i];
  end

  for (genvar j = 0; j < NUM_RES; j++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) res_q[j] <= '0;
      else if (eng_done) res_q[j] <= eng_results[j*DATA_W +: DATA_W];
    end
    assign res_flat[j*DATA_W +: DATA_W] = res_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (kick)     out_valid <= 1'b0;
    else if (eng_done) out_valid <= 1'b1;
  end

  assign res0_word = res_q[0];

  always_comb begin
    rd_word = '0;
    case (rd_kind)
      REG_OPERAND: for (int i = 0; i < NUM_OPS; i++) if (rd_idx == i) rd_word = op_q[i];
      REG_KICK:    rd_word = {{(DATA_W-1){1'b0}}, out_valid};
      REG_RESULT:  for (int j = 0; j < NUM_RES; j++) if (rd_idx == RES_IDX + j) rd_word = res_q[j];
      default:     rd_word = '0;
    endcase
  end

  // R4: a kick always leaves results-ready clear
  p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !out_valid);
  // R4: start pulse is a single cycle
  p_kick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  // R5: done without kick sets results-ready
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !kick |=> out_valid);
  // R5: captured results hold between done strobes
  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done |=> $stable(res_flat));
endmodule

// File: rtl/accw_rd_chan.sv
module accw_rd_chan
  import accw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RES_BASE = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic              out_valid,
  input  logic              kick,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] res0_word,
  output logic              pending
);
  localparam logic [ADDR_W-3:0] RES_IDX = (ADDR_W-2)'(RES_BASE / 4);

  logic results_ready, is_first_res, ar_hs;

  assign results_ready = out_valid && !kick;
  assign is_first_res  = (araddr[ADDR_W-1:2] == RES_IDX);
  assign arready       = !rvalid && !pending;
  assign ar_hs         = arvalid && arready;
  assign rresp         = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else if (ar_hs) begin
      if (is_first_res && !results_ready) begin
        pending <= 1'b1;
      end else begin
        rvalid <= 1'b1;
        rdata  <= rd_word;
      end
    end else if (pending && results_ready) begin
      pending <= 1'b0;
      rvalid  <= 1'b1;
      rdata   <= res0_word;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  // R6: no address taken while a read is held back
  p_hold_blocks_ar_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !arready && !rvalid);
  // R9: a held read is not released while results are not ready
  p_no_early_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !results_ready |=> !rvalid);
  // R10: read data stable under backpressure
  p_rdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/accw_top.sv
module accw_top
  import accw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_OPS  = 6,
  parameter int unsigned NUM_RES  = 4,
  parameter int unsigned RES_BASE = 32'h20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         s_awaddr,
  input  logic                      s_awvalid,
  output logic                      s_awready,
  input  logic [31:0]               s_wdata,
  input  logic [3:0]                s_wstrb,
  input  logic                      s_wvalid,
  output logic                      s_wready,
  output logic [1:0]                s_bresp,
  output logic                      s_bvalid,
  input  logic                      s_bready,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  output logic [31:0]               s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  output logic                      eng_start,
  output logic [NUM_OPS*32-1:0]     eng_operands,
  input  logic                      eng_done,
  input  logic [NUM_RES*32-1:0]     eng_results
);
  logic              wr_fire, out_valid, kick, pending;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rd_word, res0_word;
  logic [STRB_W-1:0] wr_strb;

  assign eng_start = kick;

  accw_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  accw_regs #(.ADDR_W(ADDR_W), .NUM_OPS(NUM_OPS), .NUM_RES(NUM_RES), .RES_BASE(RES_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .eng_done(eng_done), .eng_results(eng_results), .rd_addr(s_araddr),
    .eng_operands(eng_operands), .kick(kick), .out_valid(out_valid),
    .rd_word(rd_word), .res0_word(res0_word)
  );

  accw_rd_chan #(.ADDR_W(ADDR_W), .RES_BASE(RES_BASE)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .out_valid(out_valid), .kick(kick), .rd_word(rd_word), .res0_word(res0_word),
    .pending(pending)
  );

  // R4: start pulse ends with results-ready clear
  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !out_valid);
endmodule

// File: tb/accw_top_tb.sv
`timescale 1ns/1ps
module accw_top_tb;
  localparam int NOPS = 6;
  localparam int NRES = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, arready, rvalid, eng_start;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [NOPS*32-1:0] eng_operands;
  logic        eng_done = 0;
  logic [NRES*32-1:0] eng_results = 0;

  int checks = 0, errors = 0;
  int starts_seen = 0, starts_exp = 0;
  logic [31:0] op_m [NOPS];
  logic [31:0] res_m [NRES];
  logic        bv_prev = 0;
  logic [7:0]  pw_addr; logic [31:0] pw_data; logic [3:0] pw_strb;

  always #5 clk = ~clk;

  accw_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .eng_start(eng_start), .eng_operands(eng_operands),
    .eng_done(eng_done), .eng_results(eng_results)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model: apply a write when its response first appears, compare operands every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (bvalid && !bv_prev && pw_addr < 8'(NOPS*4)) begin
        for (int b = 0; b < 4; b++)
          if (pw_strb[b]) op_m[pw_addr>>2][b*8 +: 8] = pw_data[b*8 +: 8];
      end
      bv_prev = bvalid;
      if (eng_start) starts_seen++;
      for (int k = 0; k < NOPS; k++)
        chk(eng_operands[k*32 +: 32] === op_m[k], "R2", "operand bus word", eng_operands[k*32 +: 32], op_m[k]);
    end
  end

  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int mode);
    pw_addr = a; pw_data = d; pw_strb = s;
    if (a == 8'h18) starts_exp++;
    fork
      begin
        if (mode == 2) repeat (3) @(negedge clk);
        @(negedge clk); awvalid = 1; awaddr = a;
        while (!awready) @(negedge clk);
        @(posedge clk); #1 awvalid = 0;
      end
      begin
        if (mode == 1) begin
          repeat (3) @(negedge clk);
          chk(!awready && !bvalid, "R3", "address held, no response yet", {awready, bvalid}, 0);
        end
        @(negedge clk); wvalid = 1; wdata = d; wstrb = s;
        while (!wready) @(negedge clk);
        @(posedge clk); #1 wvalid = 0;
      end
    join
    if (mode == 2) chk(!bvalid, "R3", "no response before address", bvalid, 0);
    while (!bvalid) @(negedge clk);
    chk(bresp == 2'b00, "R3", "bresp okay", bresp, 0);
    @(negedge clk);
    chk(bvalid && !awready, "R3", "response held without bready", bvalid, 1);
    bready = 1; @(posedge clk); #1 bready = 0;
  endtask

  task automatic axi_read(input logic [7:0] a, input int rdelay, output logic [31:0] d, output int lat);
    @(negedge clk); arvalid = 1; araddr = a;
    while (!arready) @(negedge clk);
    @(posedge clk); #1 arvalid = 0;
    lat = 1;
    @(negedge clk);
    while (!rvalid && lat < 500) begin lat++; @(negedge clk); end
    d = rdata;
    chk(rresp == 2'b00, "R10", "rresp okay", rresp, 0);
    for (int i = 0; i < rdelay; i++) begin
      @(negedge clk);
      chk(rvalid && rdata == d, "R10", "rdata held under backpressure", rdata, d);
    end
    rready = 1; @(posedge clk); #1 rready = 0;
  endtask

  task automatic engine_finish(input logic [31:0] r0, r1, r2, r3);
    @(negedge clk);
    eng_done = 1; eng_results = {r3, r2, r1, r0};
    res_m[0] = r0; res_m[1] = r1; res_m[2] = r2; res_m[3] = r3;
    @(posedge clk); #1 eng_done = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat;
    for (int k = 0; k < NOPS; k++) op_m[k] = 0;
    for (int k = 0; k < NRES; k++) res_m[k] = 0;
    pw_addr = 8'hFF; pw_data = 0; pw_strb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(awready && wready && arready, "R1", "ready outputs", {awready, wready, arready}, 3'b111);
    chk(!bvalid && !rvalid && !eng_start, "R1", "valid outputs idle", {bvalid, rvalid, eng_start}, 0);
    chk(eng_operands == 0, "R1", "operands zero", eng_operands[31:0], 0);
    axi_read(8'h24, 0, d, lat);
    chk(d == 0, "R1", "result1 zero after reset", d, 0);

    // R2 / R3: three arrival orders
    axi_write(8'h00, 32'h1111_2222, 4'hF, 0);
    axi_write(8'h04, 32'hA5A5_0F0F, 4'hF, 1);
    axi_write(8'h14, 32'hDEAD_BEEF, 4'hF, 2);
    axi_read(8'h00, 0, d, lat); chk(d == 32'h1111_2222, "R2", "op0 readback", d, 32'h1111_2222);
    axi_read(8'h04, 0, d, lat); chk(d == 32'hA5A5_0F0F, "R3", "op1 address first", d, 32'hA5A5_0F0F);
    axi_read(8'h14, 0, d, lat); chk(d == 32'hDEAD_BEEF, "R3", "op5 data first", d, 32'hDEAD_BEEF);
    // R2 byte strobes
    axi_write(8'h0C, 32'h4433_2211, 4'hF, 0);
    axi_write(8'h0C, 32'hCCBB_AA99, 4'b0101, 0);
    axi_read(8'h0C, 0, d, lat); chk(d == 32'h44BB_2299, "R2", "strobe merge", d, 32'h44BB_2299);

    // R4 ready bit clear before any done
    axi_read(8'h18, 0, d, lat); chk(d == 0, "R4", "ready bit clear", d, 0);
    axi_write(8'h18, 32'h0, 4'hF, 0);

    // R6 held read, released by done
    fork
      begin
        axi_read(8'h20, 0, d, lat);
        chk(d == 32'h0000_0123, "R6", "released first result", d, 32'h0000_0123);
      end
      begin
        repeat (6) @(negedge clk);
        chk(!rvalid && !arready, "R6", "read held back", {rvalid, arready}, 0);
        engine_finish(32'h0000_0123, 32'h0000_0456, 32'h0000_0789, 32'hFFFF_FFF0);
      end
    join
    axi_read(8'h18, 0, d, lat); chk(d == 1, "R5", "ready bit set after done", d, 1);
    // R7 immediate reads with backpressure (R10)
    axi_read(8'h20, 0, d, lat); chk(lat == 1 && d == res_m[0], "R7", "first result immediate when ready", d, res_m[0]);
    axi_read(8'h24, 3, d, lat); chk(lat == 1 && d == res_m[1], "R7", "result1 immediate", d, res_m[1]);
    axi_read(8'h2C, 0, d, lat); chk(d == res_m[3], "R5", "result3 captured", d, res_m[3]);

    // R8 ignored writes and unmapped reads
    axi_write(8'h24, 32'h5555_5555, 4'hF, 0);
    axi_read(8'h24, 0, d, lat); chk(d == res_m[1], "R8", "result not writable", d, res_m[1]);
    axi_write(8'h3C, 32'h7777_7777, 4'hF, 1);
    axi_read(8'h3C, 0, d, lat); chk(d == 0, "R8", "unmapped reads zero", d, 0);
    axi_read(8'h1C, 0, d, lat); chk(d == 0, "R8", "gap reads zero", d, 0);

    // R4 kick clears ready, results held (R5)
    axi_write(8'h18, 32'hFFFF_FFFF, 4'hF, 2);
    axi_read(8'h18, 0, d, lat); chk(d == 0, "R4", "ready bit cleared by kick", d, 0);
    axi_read(8'h28, 0, d, lat); chk(lat == 1 && d == res_m[2], "R7", "result2 while not ready", d, res_m[2]);

    // R9 kick during a held read
    fork
      begin
        axi_read(8'h20, 0, d, lat);
        chk(d == 32'hBEEF_0009, "R9", "released with new result", d, 32'hBEEF_0009);
      end
      begin
        repeat (4) @(negedge clk);
        axi_write(8'h18, 32'h1, 4'hF, 0);
        repeat (3) @(negedge clk);
        chk(!rvalid, "R9", "still held after second kick", rvalid, 0);
        engine_finish(32'hBEEF_0009, 32'h1, 32'h2, 32'h3);
      end
    join

    repeat (3) @(negedge clk);
    chk(starts_seen == starts_exp, "R4", "start pulse count", starts_seen, starts_exp);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule